// File: doc/BRIEF.md
# Sequential Complex Divider

This block divides a complex dividend `a` by a complex divisor `b`. Both arrive as signed 12-bit real and imaginary parts. The block multiplies the dividend by the conjugate of the divisor and divides by the squared magnitude of the divisor. The real result is (ar·br + ai·bi)/(br² + bi²). The imaginary result is (ai·br − ar·bi)/(br² + bi²).

The block trades throughput for area. One signed multiplier produces all six products, one per clock. A single radix-2 restoring divider then forms the two quotients in turn. The divider works on magnitudes, produces one quotient bit per clock and applies the sign at the end. The divisor's squared magnitude is formed first and held in a register. The imaginary numerator is formed while the divider is still busy on the real quotient.

A caller pulses `start` while the block is idle and then waits for `done`. Both results are delivered in signed Q4.12 format. A zero divisor is reported with a flag instead of a result.

Top module: `cplx_div_seq`

## Requirements
- R1: A `start` sampled high at a rising edge while `busy` is low captures `a_re`, `a_im`, `b_re` and `b_im`. `busy` is high after that edge.
- R2: For a nonzero divisor, `q_re` equals (ar·br + ai·bi)·4096/(br² + bi²), rounded and saturated as in R4 and R5, as a signed 16-bit value with 12 fraction bits.
- R3: For a nonzero divisor, `q_im` equals (ai·br − ar·bi)·4096/(br² + bi²), rounded and saturated as in R4 and R5, in the same format as `q_re`.
- R4: Rounding is to nearest, with exact halves rounded away from zero. A result and its negation therefore differ only in sign: 2/3 gives 2731 and −2/3 gives −2731.
- R5: A positive result above 32767 is reported as 32767. A negative result below −32768 is reported as −32768.
- R6: When br² + bi² is zero, `div_by_zero` and `done` are high together for one cycle, and both `q_re` and `q_im` read 0. `done` rises 2 cycles after the accepting edge.
- R7: For a nonzero divisor, `done` rises exactly 40 clock cycles after the accepting edge. `busy` stays high until that cycle and is low while `done` is high.
- R8: `done` is high for exactly one cycle per operation. `div_by_zero` is never high without `done`.
- R9: `start` and operand changes while `busy` is high are ignored. The running operation's results and timing are unchanged.
- R10: `q_re` and `q_im` change only in the cycle in which `done` is high. Otherwise they hold the last reported results.
- R11: After reset, `busy`, `done` and `div_by_zero` are low, and `q_re` and `q_im` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division when idle |
| a_re | input | 12 | Dividend real part, signed |
| a_im | input | 12 | Dividend imaginary part, signed |
| b_re | input | 12 | Divisor real part, signed |
| b_im | input | 12 | Divisor imaginary part, signed |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: results valid |
| div_by_zero | output | 1 | Divisor was zero, pulses with done |
| q_re | output | 16 | Real quotient, signed Q4.12 |
| q_im | output | 16 | Imaginary quotient, signed Q4.12 |

## Verification
The counting starts at the rising edge that accepts `start`. For a nonzero divisor both quotients and `done` are due 40 edges later. For a zero divisor `done`, `div_by_zero` and the zeroed outputs are due 2 edges later. The bench drives inputs and samples outputs on falling edges. It counts each falling edge after the accepting edge and requires `done` to appear at exactly the due count. Expected values are compared in that same sample, and the hold of the results and the fall of `done` are checked in the following sample.

// File: rtl/cplx_div_seq.sv
module cplx_div_seq #(
  parameter int W_IN  = 12,
  parameter int W_OUT = 16,
  parameter int FRAC  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [W_IN-1:0]  a_re,
  input  logic signed [W_IN-1:0]  a_im,
  input  logic signed [W_IN-1:0]  b_re,
  input  logic signed [W_IN-1:0]  b_im,
  output logic                    busy,
  output logic                    done,
  output logic                    div_by_zero,
  output logic signed [W_OUT-1:0] q_re,
  output logic signed [W_OUT-1:0] q_im
);

  localparam int WP = 2 * W_IN;
  localparam int WN = WP + 1;
  localparam int WD = WP;
  localparam int WR = WD + 1;
  localparam int QB = W_OUT + 1;
  localparam int SH = QB - FRAC - 1;
  localparam int WC = $clog2(QB + 1);
  localparam logic [QB:0] LIM_P = (QB+1)'((1 << (W_OUT-1)) - 1);
  localparam logic [QB:0] LIM_N = (QB+1)'(1 << (W_OUT-1));

  typedef enum logic [1:0] {S_IDLE, S_MUL, S_DRE, S_DIM} st_t;

  st_t                    st;
  logic [1:0]             ph, ov;
  logic signed [W_IN-1:0] ar, ai, br, bi;
  logic signed [W_IN-1:0] m_x, m_y;
  logic signed [WP-1:0]   prod;
  logic signed [WN-1:0]   acc, num_im, n_src;
  logic [WD-1:0]          den, den_next, rem;
  logic [WN-1:0]          n_mag;
  logic                   n_neg, n_ovf, ld, stepping, ge;
  logic [QB-1:0]          lo, qa;
  logic [WC-1:0]          cnt;
  logic                   neg, sat;
  logic [WR-1:0]          t;
  logic [QB:0]            rnd;
  logic signed [W_OUT-1:0] res, res_re;

  always_comb begin
    m_x = br;
    m_y = bi;
    case (st)
      S_MUL: case (ph)
        2'd0:    begin m_x = br; m_y = br; end
        2'd1:    begin m_x = bi; m_y = bi; end
        2'd2:    begin m_x = ar; m_y = br; end
        default: begin m_x = ai; m_y = bi; end
      endcase
      S_DRE: if (ov == 2'd0) begin m_x = ai; m_y = br; end
             else            begin m_x = ar; m_y = bi; end
      default: ;
    endcase
  end

  assign prod     = WP'(m_x) * WP'(m_y);
  assign den_next = acc[WD-1:0] + prod;

  assign n_src = (st == S_MUL) ? acc + WN'(prod) : num_im;
  assign n_neg = n_src[WN-1];
  assign n_mag = n_neg ? -n_src : n_src;
  assign n_ovf = (WD+SH)'(n_mag) >= {den, {SH{1'b0}}};

  assign ld       = (st == S_MUL && ph == 2'd3) || (st == S_DRE && cnt == '0);
  assign stepping = (st == S_DRE || st == S_DIM) && cnt != '0;
  assign t        = {rem, lo[QB-1]};
  assign ge       = t >= {1'b0, den};

  assign rnd = ({1'b0, qa} + (QB+1)'(1)) >> 1;

  always_comb begin
    if (!neg) res = (sat || rnd > LIM_P) ? W_OUT'(LIM_P) : W_OUT'(rnd);
    else      res = (sat || rnd > LIM_N) ? W_OUT'(LIM_N) : -W_OUT'(rnd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0;
      lo  <= '0;
      qa  <= '0;
      cnt <= '0;
      neg <= 1'b0;
      sat <= 1'b0;
    end else if (ld) begin
      rem <= WD'(n_mag >> SH);
      lo  <= {n_mag[SH-1:0], {(QB-SH){1'b0}}};
      qa  <= '0;
      cnt <= WC'(QB);
      neg <= n_neg;
      sat <= n_ovf;
    end else if (stepping) begin
      rem <= ge ? WD'(t - {1'b0, den}) : WD'(t);
      lo  <= lo << 1;
      qa  <= {qa[QB-2:0], ge};
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      ph          <= '0;
      ov          <= '0;
      ar          <= '0;
      ai          <= '0;
      br          <= '0;
      bi          <= '0;
      acc         <= '0;
      den         <= '0;
      num_im      <= '0;
      res_re      <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      div_by_zero <= 1'b0;
      q_re        <= '0;
      q_im        <= '0;
    end else begin
      done        <= 1'b0;
      div_by_zero <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          ar   <= a_re;
          ai   <= a_im;
          br   <= b_re;
          bi   <= b_im;
          ph   <= '0;
          busy <= 1'b1;
          st   <= S_MUL;
        end
        S_MUL: begin
          ph <= ph + 1'b1;
          case (ph)
            2'd0: acc <= WN'(prod);
            2'd1: begin
              den <= den_next;
              if (den_next == '0) begin
                q_re        <= '0;
                q_im        <= '0;
                done        <= 1'b1;
                div_by_zero <= 1'b1;
                busy        <= 1'b0;
                st          <= S_IDLE;
              end
            end
            2'd2: acc <= WN'(prod);
            default: begin
              ov <= '0;
              st <= S_DRE;
            end
          endcase
        end
        S_DRE: begin
          if (ov == 2'd0) begin
            acc <= WN'(prod);
            ov  <= 2'd1;
          end else if (ov == 2'd1) begin
            num_im <= acc - WN'(prod);
            ov     <= 2'd2;
          end
          if (cnt == '0) begin
            res_re <= res;
            st     <= S_DIM;
          end
        end
        default: if (cnt == '0) begin
          q_re <= res_re;
          q_im <= res;
          done <= 1'b1;
          busy <= 1'b0;
          st   <= S_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/cplx_div_seq_chk.sv
module cplx_div_seq_chk #(
  parameter int W_OUT = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic                    div_by_zero,
  input logic signed [W_OUT-1:0] q_re,
  input logic signed [W_OUT-1:0] q_im
);

  a_r1_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r7_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_dbz_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    div_by_zero |-> (done && q_re == '0 && q_im == '0));

  a_r10_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    (q_re != $past(q_re) || q_im != $past(q_im)) |-> done);

endmodule

bind cplx_div_seq cplx_div_seq_chk #(.W_OUT(W_OUT)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .start(start),
  .busy(busy),
  .done(done),
  .div_by_zero(div_by_zero),
  .q_re(q_re),
  .q_im(q_im)
);

// File: tb/cplx_div_seq_tb_top.sv
module cplx_div_seq_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic signed [11:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
  logic busy, done, div_by_zero;
  logic signed [15:0] q_re, q_im;

  int checks = 0;
  int errors = 0;
  longint prev_re = 0, prev_im = 0;

  always #4 clk = ~clk;

  cplx_div_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .busy(busy), .done(done), .div_by_zero(div_by_zero),
    .q_re(q_re), .q_im(q_im)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint ref_q(input longint n, input longint d);
    longint mag, r;
    mag = (n < 0) ? -n : n;
    r = (mag * 8192 + d) / (2 * d);
    if (n >= 0) return (r > 32767) ? 32767 : r;
    return (r > 32768) ? -32768 : -r;
  endfunction

  task automatic run_op(input int ar, input int ai, input int br, input int bi,
                        input int poke, input string tre, input string tim);
    longint d, nre, nim, ere, eim;
    int k, exp_lat;
    bit busy_ok, hold_ok;
    d   = longint'(br) * br + longint'(bi) * bi;
    nre = longint'(ar) * br + longint'(ai) * bi;
    nim = longint'(ai) * br - longint'(ar) * bi;
    if (d == 0) begin ere = 0; eim = 0; exp_lat = 2; end
    else begin ere = ref_q(nre, d); eim = ref_q(nim, d); exp_lat = 40; end
    @(negedge clk);
    a_re = 12'(ar); a_im = 12'(ai); b_re = 12'(br); b_im = 12'(bi);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1", "busy after accept", longint'(busy), 1);
    k = 0;
    busy_ok = 1'b1;
    hold_ok = 1'b1;
    while (!done && k < 100) begin
      if (!busy) busy_ok = 1'b0;
      if (q_re != prev_re || q_im != prev_im) hold_ok = 1'b0;
      @(negedge clk);
      k++;
      if (k == poke) begin
        start = 1'b1;
        a_re = 12'($urandom); a_im = 12'($urandom);
        b_re = 12'($urandom); b_im = 12'($urandom);
      end
      if (k == poke + 1) start = 1'b0;
    end
    start = 1'b0;
    chk(k == exp_lat, (d == 0) ? "R6" : "R7", "done latency", k, exp_lat);
    chk(busy_ok, "R7", "busy held until done", busy_ok, 1);
    chk(hold_ok, "R10", "outputs held while busy", hold_ok, 1);
    chk(busy == 1'b0, "R7", "busy low with done", longint'(busy), 0);
    chk(div_by_zero == (d == 0), "R6", "div_by_zero flag", longint'(div_by_zero), longint'(d == 0));
    chk(q_re == ere, (d == 0) ? "R6" : tre, "q_re", q_re, ere);
    chk(q_im == eim, (d == 0) ? "R6" : tim, "q_im", q_im, eim);
    if (poke > 0) chk(q_re == ere && q_im == eim, "R9", "start while busy ignored", q_re, ere);
    prev_re = q_re;
    prev_im = q_im;
    @(negedge clk);
    chk(done == 1'b0, "R8", "done one cycle", longint'(done), 0);
    chk(div_by_zero == 1'b0, "R8", "flag one cycle", longint'(div_by_zero), 0);
    chk(q_re == prev_re && q_im == prev_im, "R10", "results held after done", q_re, prev_re);
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240613));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && div_by_zero == 0, "R11", "control after reset", busy, 0);
    chk(q_re == 0 && q_im == 0, "R11", "results after reset", q_re, 0);

    run_op(1, 0, 1, 0, 0, "R2", "R3");
    run_op(1, 1, 1, -1, 0, "R2", "R3");
    run_op(5, -7, 3, 2, 0, "R2", "R3");
    run_op(1, 0, 3, 0, 0, "R4", "R4");
    run_op(-1, 0, 3, 0, 0, "R4", "R4");
    run_op(2, 0, 3, 0, 0, "R4", "R4");
    run_op(-2, 0, 3, 0, 0, "R4", "R4");
    run_op(0, 2, 0, 3, 0, "R4", "R4");
    run_op(2047, 2047, 1, 0, 0, "R5", "R5");
    run_op(-2048, -2048, 1, 0, 0, "R5", "R5");
    run_op(-2048, 7, 0, 1, 0, "R5", "R5");
    run_op(8, 0, 1, 0, 0, "R5", "R5");
    run_op(-8, 0, 1, 0, 0, "R5", "R5");
    run_op(123, -45, 0, 0, 0, "R6", "R6");
    run_op(3, 4, 5, 6, 7, "R9", "R9");
    run_op(9, 9, 0, 0, 1, "R9", "R9");
    run_op(-2048, -2048, -2048, -2048, 0, "R2", "R3");

    for (int i = 0; i < 300; i++) begin
      int ar, ai, br, bi, pk;
      ar = int'($urandom % 4096) - 2048;
      ai = int'($urandom % 4096) - 2048;
      if ($urandom % 4 == 0) begin
        br = int'($urandom % 7) - 3;
        bi = int'($urandom % 7) - 3;
      end else begin
        br = int'($urandom % 4096) - 2048;
        bi = int'($urandom % 4096) - 2048;
      end
      pk = ($urandom % 8 == 0) ? 1 + int'($urandom % 35) : 0;
      run_op(ar, ai, br, bi, pk, "R2", "R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule